// File: doc/BRIEF.md
# Pipelined Converter Digital Correction

This block sits behind a nine-stage pipelined quantizer and turns the stream of raw stage decisions into one corrected 10-bit sample on every clock. Each stage hands over a 2-bit code per cycle. The stages work on the same input sample one after another, so stage k offers its code for a sample k-1 cycles after stage 1 did. The block gives each stage a delay line of its own length so that the nine codes of a sample meet in the same cycle.

Once the codes are aligned, the block overlap-adds them. Each stage's code is weighted one bit lower than the code of the stage before it. That lets the redundant half-bit of each stage absorb decision errors, so no output code goes missing. The result is a straight offset binary word: negative full scale reads all zeros, mid-scale reads a single leading one, and full scale reads all ones. A valid flag marks the cycles in which the word belongs to a sample whose nine codes all arrived after reset.

Top module: `pipe_corr`

## Requirements
- R1: After a synchronous reset is released, `validOut` is low for the first 9 clock edges. It rises after the 9th edge and stays high until the next reset.
- R2: Stage k (k = 1 for the MSB stage, 9 for the last) presents its code for a sample k-1 cycles after stage 1. The corrected word for that sample appears on `dataOut` after the clock edge that comes 8 edges after the edge that captured stage 1's code.
- R3: The word is the sum over k of code_k × 2^(9-k). Stage k's code sits on bits [2k-1:2k-2] of `stageCodes`.
- R4: A code of value 3 from any of stages 1 to 8 is weighted as if it were 2.
- R5: A code of value 3 from stage 9 counts at its full value of 3.
- R6: The coding is straight offset binary. All stages at 0 gives 0. Stage 1 at 2 with all other stages at 0 gives 512. Every stage at its maximum gives 1023, and the word never exceeds 1023.
- R7: When `rst` is high at a clock edge, `dataOut` is 0 and `validOut` is low after that edge, and all aligned history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all stages and the correction run at this rate |
| rst | input | 1 | Synchronous reset, active high |
| stageCodes | input | 18 | Nine 2-bit stage codes; stage k on bits [2k-1:2k-2] |
| dataOut | output | 10 | Corrected straight offset binary sample |
| validOut | output | 1 | High when `dataOut` holds a fully aligned sample |

## Verification
The bench replays per-sample code sets with the stage skew applied and gives every sample a distinct mix of codes. A wrong delay for any stage would pair that stage's code with a neighbouring sample and corrupt the result. Single-stage walking patterns expose a stage added at the wrong weight as a wrong power of two. Streams full of code 3 show whether stages 1 to 8 are clamped to 2 while stage 9 keeps its 3; a design that gets this wrong lands above 1023 or wraps. Reset applied in the middle of a stream shows whether the flag drops and rises again after exactly nine edges, and whether stale codes leak into the first words that follow.

// File: rtl/pipe_corr_pkg.sv
package pipe_corr_pkg;
  localparam int STAGE_COUNT = 9;
  localparam int CODE_W      = 2;

  typedef struct packed {
    logic clearPipe;
    logic fillDone;
  } corr_ctrl_t;
endpackage

// File: rtl/corr_delay.sv
module corr_delay #(
  parameter int DEPTH = 1,
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [DEPTH-1:0][WIDTH-1:0] taps;

  always_ff @(posedge clk) begin
    if (clear) begin
      taps <= '0;
    end else begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
        taps[i] <= taps[i-1];
      end
    end
  end

  assign dout = taps[DEPTH-1];
endmodule

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import pipe_corr_pkg::*;
#(
  parameter int NUM_STAGES = STAGE_COUNT
) (
  input  logic       clk,
  input  logic       rst,
  output corr_ctrl_t ctrl
);
  localparam int CNT_W = $clog2(NUM_STAGES + 1);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(NUM_STAGES);

  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (fillCnt != FILL_LAST) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  assign ctrl.clearPipe = rst;
  assign ctrl.fillDone  = (fillCnt == FILL_LAST);
endmodule

// File: rtl/corr_datapath.sv
module corr_datapath
  import pipe_corr_pkg::*;
#(
  parameter int NUM_STAGES = STAGE_COUNT,
  parameter int OUT_W      = NUM_STAGES + 1
) (
  input  logic                         clk,
  input  corr_ctrl_t                   ctrl,
  input  logic [CODE_W*NUM_STAGES-1:0] stageCodes,
  output logic [OUT_W-1:0]             dataOut,
  output logic                         validOut
);
  localparam int ACC_W = OUT_W + 1;
  localparam logic [ACC_W-1:0] SAT_LIMIT = {1'b0, {OUT_W{1'b1}}};

  logic [NUM_STAGES-1:0][CODE_W-1:0] alignedCodes;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accSat;
  logic [CODE_W-1:0] eff;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    localparam int LAG = NUM_STAGES - 1 - s;
    if (LAG == 0) begin : g_direct
      assign alignedCodes[s] = stageCodes[CODE_W*s +: CODE_W];
    end else begin : g_delayed
      corr_delay #(.DEPTH(LAG), .WIDTH(CODE_W)) u_delay (
        .clk  (clk),
        .clear(ctrl.clearPipe),
        .din  (stageCodes[CODE_W*s +: CODE_W]),
        .dout (alignedCodes[s])
      );
    end
  end

  always_comb begin
    acc = '0;
    eff = '0;
    for (int k = 0; k < NUM_STAGES; k++) begin
      eff = alignedCodes[k];
      if ((k < NUM_STAGES - 1) && (eff == 2'd3)) begin
        eff = 2'd2;
      end
      acc = acc + ({{(ACC_W-CODE_W){1'b0}}, eff} << (NUM_STAGES - 1 - k));
    end
    accSat = (acc > SAT_LIMIT) ? SAT_LIMIT : acc;
  end

  always_ff @(posedge clk) begin
    if (ctrl.clearPipe) begin
      dataOut <= '0;
    end else begin
      dataOut <= accSat[OUT_W-1:0];
    end
  end

  assign validOut = ctrl.fillDone;
endmodule

// File: rtl/pipe_corr.sv
module pipe_corr
  import pipe_corr_pkg::*;
#(
  parameter int NUM_STAGES = STAGE_COUNT,
  parameter int OUT_W      = NUM_STAGES + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CODE_W*NUM_STAGES-1:0] stageCodes,
  output logic [OUT_W-1:0]             dataOut,
  output logic                         validOut
);
  corr_ctrl_t ctrl;

  corr_ctrl #(.NUM_STAGES(NUM_STAGES)) u_ctrl (
    .clk (clk),
    .rst (rst),
    .ctrl(ctrl)
  );

  corr_datapath #(.NUM_STAGES(NUM_STAGES), .OUT_W(OUT_W)) u_dp (
    .clk       (clk),
    .ctrl      (ctrl),
    .stageCodes(stageCodes),
    .dataOut   (dataOut),
    .validOut  (validOut)
  );
endmodule

// File: rtl/pipe_corr_chk.sv
module pipe_corr_chk #(
  parameter int NUM_STAGES = 9,
  parameter int OUT_W      = NUM_STAGES + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [OUT_W-1:0] dataOut,
  input logic             validOut,
  input logic [1:0]       alignedHead
);
  localparam int CNT_W = $clog2(NUM_STAGES + 2);
  localparam logic [CNT_W-1:0] WAIT_EDGES = CNT_W'(NUM_STAGES);
  localparam logic [OUT_W-1:0] HALF_SCALE = OUT_W'(1) << (OUT_W - 1);

  logic [CNT_W-1:0] edgesSinceRst;

  always_ff @(posedge clk) begin
    if (rst) begin
      edgesSinceRst <= '0;
    end else if (edgesSinceRst != WAIT_EDGES) begin
      edgesSinceRst <= edgesSinceRst + 1'b1;
    end
  end

  // R1
  fill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (edgesSinceRst < WAIT_EDGES) |-> !validOut);

  // R1
  fill_done_chk: assert property (@(posedge clk) disable iff (rst)
    (edgesSinceRst == WAIT_EDGES) |-> validOut);

  // R1
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |=> validOut);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!validOut && dataOut == '0));

  // R3
  msb_low_chk: assert property (@(posedge clk) disable iff (rst)
    (alignedHead == 2'd0) |=> (dataOut < HALF_SCALE));

  // R3
  msb_high_chk: assert property (@(posedge clk) disable iff (rst)
    (alignedHead >= 2'd2) |=> (dataOut >= HALF_SCALE));
endmodule

bind pipe_corr pipe_corr_chk #(.NUM_STAGES(NUM_STAGES), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dataOut    (dataOut),
  .validOut   (validOut),
  .alignedHead(u_dp.alignedCodes[0])
);

// File: tb/pipe_corr_bench.sv
`timescale 1ns/1ps
module pipe_corr_bench;
  localparam int NS = 9;
  localparam int MAXLEN = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2*NS-1:0] stageCodes = '0;
  logic [NS:0]   dataOut;
  logic          validOut;

  int checks = 0;
  int errors = 0;
  int codeMem [0:MAXLEN-1][1:NS];
  int streamLen = 0;

  always #10 clk = ~clk;

  pipe_corr u_pipe_corr (
    .clk(clk), .rst(rst), .stageCodes(stageCodes),
    .dataOut(dataOut), .validOut(validOut)
  );

  function automatic int expWord(int n);
    int s = 0;
    for (int k = 1; k <= NS; k++) begin
      int c = codeMem[n][k];
      if (k < NS && c == 3) c = 2;
      s += c * (1 << (NS - k));
    end
    if (s > 1023) s = 1023;
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic driveCycle(int t);
    for (int k = 1; k <= NS; k++) begin
      int n = t - (k - 1);
      int c = (n >= 0 && n < streamLen) ? codeMem[n][k] : 0;
      stageCodes[2*(k-1) +: 2] = c[1:0];
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    stageCodes = '0;
    @(negedge clk);
    @(negedge clk);
    // R7: outputs cleared after a reset edge
    check("R7 reset data", int'(dataOut), 0);
    check("R7 reset valid", int'(validOut), 0);
    rst = 1'b0;
  endtask

  // Run cycles 0..lastT after reset release, checking flag and words (R1, R2)
  task automatic runStream(string req, int lastT);
    for (int t = 0; t <= lastT; t++) begin
      check("R1 valid", int'(validOut), (t >= NS) ? 1 : 0);
      if (t >= NS && (t - NS) < streamLen)
        check(req, int'(dataOut), expWord(t - NS));
      driveCycle(t);
      @(negedge clk);
    end
  endtask

  task automatic test_zero_and_mid();
    streamLen = 3;
    for (int k = 1; k <= NS; k++) begin
      codeMem[0][k] = 0;
      codeMem[1][k] = 0;
      codeMem[2][k] = 0;
    end
    codeMem[1][1] = 2;
    doReset();
    runStream("R6 zero/mid", streamLen + NS);
    check("R6 mid literal", expWord(1), 512);
  endtask

  task automatic test_fullscale();
    streamLen = 2;
    for (int k = 1; k <= NS; k++) begin
      codeMem[0][k] = (k == NS) ? 3 : 2;
      codeMem[1][k] = 3;
    end
    doReset();
    runStream("R6 full scale", streamLen + NS);
    check("R6 full literal", expWord(0), 1023);
  endtask

  task automatic test_walk();
    streamLen = 2 * NS;
    for (int n = 0; n < streamLen; n++)
      for (int k = 1; k <= NS; k++)
        codeMem[n][k] = (k == (n % NS) + 1) ? 1 + (n / NS) : 0;
    doReset();
    runStream("R3 walking weight", streamLen + NS);
  endtask

  task automatic test_mixed();
    streamLen = 40;
    for (int n = 0; n < streamLen; n++)
      for (int k = 1; k <= NS; k++)
        codeMem[n][k] = (n * 7 + k * 3 + n * k) % 4;
    doReset();
    runStream("R2 alignment mixed", streamLen + NS);
  endtask

  task automatic test_redundant();
    streamLen = NS;
    for (int n = 0; n < streamLen; n++)
      for (int k = 1; k <= NS; k++)
        codeMem[n][k] = (k == n + 1) ? 3 : 0;
    doReset();
    runStream("R4 R5 code three", streamLen + NS);
    check("R4 literal", expWord(4), 32);
    check("R5 literal", expWord(NS - 1), 3);
  endtask

  task automatic test_reset_mid();
    streamLen = 20;
    for (int n = 0; n < streamLen; n++)
      for (int k = 1; k <= NS; k++)
        codeMem[n][k] = (n + k) % 3 + 1;
    doReset();
    runStream("R7 pre-reset stream", 14);
    doReset();
    for (int n = 0; n < streamLen; n++)
      for (int k = 1; k <= NS; k++)
        codeMem[n][k] = (n * 5 + k) % 3;
    runStream("R7 post-reset stream", streamLen + NS);
  endtask

  initial begin
    #(20ns * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_zero_and_mid();
    test_fullscale();
    test_walk();
    test_mixed();
    test_redundant();
    test_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule